// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores incoming frames into a ring of receive descriptors. Each descriptor holds a 4-bit status word, a byte length and a buffer pointer. The descriptors sit in a small table inside the block. The engine accepts a byte stream with valid, last and error qualifiers. It writes each byte to an external byte-addressed buffer memory at the current descriptor's pointer plus the byte offset. When the frame ends, it writes the final length and status into the descriptor.

Ownership passes through the EMPTY status bit. The engine fills only descriptors that have EMPTY set. The ring closes at whichever descriptor carries the WRAP bit. Software reads a descriptor, takes the frame, and recycles the descriptor through the register port: it writes EMPTY back, adds WRAP on the closing entry, and sets the length to zero. It then pulses `task_en`. An engine that met an occupied descriptor stays parked until that pulse arrives, and drops every frame it sees while parked.

A frame is normally usable when LAST is set, ERR is clear, and the length minus the 4-byte check sequence is larger than 14. The default frame limit is 1518 bytes.

Top module: `rxring_engine`

## Requirements
- R1: After reset, every descriptor has status EMPTY (bit 0) and length 0. Only descriptor NUM_DESC-1 also has WRAP (bit 1). Descriptor i points to buffer address i*MAX_FRAME. `ring_pos` is 0, and `parked` and `overrun` are low.
- R2: Each byte accepted into an EMPTY descriptor produces one `mem_we` pulse in the cycle after acceptance. The address is the descriptor pointer plus the byte's offset in the frame. Bytes are written in arrival order, and no write happens while `rx_valid` is low.
- R3: When a frame's last byte is accepted, the descriptor is updated one clock later, at the same edge the last byte is written. EMPTY clears, LAST (bit 2) sets, WRAP keeps its value, and the length becomes the byte count including the check sequence. In the cycle between acceptance and that edge, the descriptor still reads as EMPTY. A one-byte frame stores length 1.
- R4: A frame whose last byte arrives with `rx_error` high still uses up its descriptor, and sets ERR (bit 3) along with LAST.
- R5: After a descriptor is used, `ring_pos` moves to 0 if that descriptor had WRAP, and to the next index otherwise. Setting WRAP on an earlier entry shortens the ring.
- R6: If the current descriptor is not EMPTY when a frame starts, no byte of that frame is written and no descriptor changes. `overrun` rises and stays high until reset, and `parked` rises.
- R7: While parked, every frame is dropped, even after software has recycled the descriptor. A `task_en` pulse clears `parked`, and the next frame is stored normally.
- R8: Bytes beyond MAX_FRAME in one frame are not written. The stored length saturates at MAX_FRAME, and ERR is set.
- R9: A register-port write (`sw_wr`) replaces the status, length and pointer of descriptor `sw_idx`. The read outputs show the descriptor selected by `sw_idx` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_error | input | 1 | Frame error, sampled with rx_last |
| task_en | input | 1 | Re-arm strobe after recycling |
| sw_wr | input | 1 | Write descriptor sw_idx |
| sw_idx | input | IDX_W | Descriptor selected for read and write |
| sw_status_in | input | 4 | Status to write (ERR, LAST, WRAP, EMPTY, MSB first) |
| sw_len_in | input | LEN_W | Length to write |
| sw_ptr_in | input | ADDR_W | Buffer pointer to write |
| sw_status_out | output | 4 | Status of descriptor sw_idx |
| sw_len_out | output | LEN_W | Length of descriptor sw_idx |
| sw_ptr_out | output | ADDR_W | Buffer pointer of descriptor sw_idx |
| mem_we | output | 1 | Buffer byte write strobe |
| mem_addr | output | ADDR_W | Buffer byte address |
| mem_wdata | output | 8 | Buffer byte data |
| ring_pos | output | IDX_W | Index of the descriptor the next frame uses |
| parked | output | 1 | Engine waits for task_en |
| overrun | output | 1 | Sticky: a frame was dropped |

## Verification
The bench builds the block with four descriptors, a 32-byte frame limit and an 8-bit buffer address. With a 32-byte limit, a 40-byte frame is enough to exercise truncation without long streams. With four descriptors, the ring fills after a few frames, so the path into the parked state and back out can be driven directly. Moving WRAP onto descriptor 2 shows that the ring length follows the flag rather than the descriptor count.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    // status bit positions, software decodes these
    localparam int ST_EMPTY = 0;
    localparam int ST_WRAP  = 1;
    localparam int ST_LAST  = 2;
    localparam int ST_ERR   = 3;
    localparam int ST_W     = 4;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_FILL,
        WS_SKIP
    } walk_state_e;
endpackage

// File: rtl/rxring_desc_store.sv
module rxring_desc_store
    import rxring_pkg::*;
#(
    parameter int NUM_DESC  = 4,
    parameter int MAX_FRAME = 1518,
    parameter int ADDR_W    = 13,
    parameter int LEN_W     = 16,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [ST_W-1:0]   sw_st_w,
    input  logic [LEN_W-1:0]  sw_len_w,
    input  logic [ADDR_W-1:0] sw_ptr_w,
    output logic [ST_W-1:0]   sw_st_r,
    output logic [LEN_W-1:0]  sw_len_r,
    output logic [ADDR_W-1:0] sw_ptr_r,
    input  logic [IDX_W-1:0]  eng_idx,
    output logic              eng_empty,
    output logic              eng_wrap,
    output logic [ADDR_W-1:0] eng_ptr,
    input  logic              cm_we,
    input  logic [IDX_W-1:0]  cm_idx,
    input  logic [ST_W-1:0]   cm_st,
    input  logic [LEN_W-1:0]  cm_len
);
    logic [ST_W-1:0]   st_arr  [NUM_DESC];
    logic [LEN_W-1:0]  len_arr [NUM_DESC];
    logic [ADDR_W-1:0] ptr_arr [NUM_DESC];

    for (genvar i = 0; i < NUM_DESC; i++) begin : g_ent
        localparam logic [ST_W-1:0] RST_ST =
            (i == NUM_DESC - 1) ? ST_W'((1 << ST_EMPTY) | (1 << ST_WRAP))
                                : ST_W'(1 << ST_EMPTY);
        logic [ST_W-1:0]   st_d,  st_q;
        logic [LEN_W-1:0]  len_d, len_q;
        logic [ADDR_W-1:0] ptr_d, ptr_q;

        always_comb begin
            st_d  = st_q;
            len_d = len_q;
            ptr_d = ptr_q;
            // engine completion has priority over a software write
            if (cm_we && cm_idx == IDX_W'(i)) begin
                st_d  = cm_st;
                len_d = cm_len;
            end else if (sw_wr && sw_idx == IDX_W'(i)) begin
                st_d  = sw_st_w;
                len_d = sw_len_w;
                ptr_d = sw_ptr_w;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= RST_ST;
                len_q <= '0;
                ptr_q <= ADDR_W'(i * MAX_FRAME);
            end else begin
                st_q  <= st_d;
                len_q <= len_d;
                ptr_q <= ptr_d;
            end
        end

        assign st_arr[i]  = st_q;
        assign len_arr[i] = len_q;
        assign ptr_arr[i] = ptr_q;
    end

    assign sw_st_r   = st_arr[sw_idx];
    assign sw_len_r  = len_arr[sw_idx];
    assign sw_ptr_r  = ptr_arr[sw_idx];
    assign eng_empty = st_arr[eng_idx][ST_EMPTY];
    assign eng_wrap  = st_arr[eng_idx][ST_WRAP];
    assign eng_ptr   = ptr_arr[eng_idx];
endmodule

// File: rtl/rxring_walker.sv
module rxring_walker
    import rxring_pkg::*;
#(
    parameter int NUM_DESC  = 4,
    parameter int MAX_FRAME = 1518,
    parameter int ADDR_W    = 13,
    parameter int LEN_W     = 16,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_error,
    input  logic              task_en,
    input  logic              cur_empty,
    input  logic              cur_wrap,
    input  logic [ADDR_W-1:0] cur_ptr,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              cm_we,
    output logic [IDX_W-1:0]  cm_idx,
    output logic [ST_W-1:0]   cm_st,
    output logic [LEN_W-1:0]  cm_len,
    output logic              parked,
    output logic              overrun
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_FRAME);

    typedef struct packed {
        walk_state_e       st;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  cnt;
        logic [ADDR_W-1:0] base;
        logic              wrap;
        logic              trunc;
        logic              park;
        logic              ovr;
        logic              bwe;
        logic [ADDR_W-1:0] baddr;
        logic [7:0]        bdata;
        logic              cwe;
        logic [IDX_W-1:0]  cidx;
        logic [ST_W-1:0]   cst;
        logic [LEN_W-1:0]  clen;
    } walk_t;

    walk_t q, d;

    logic              busy;
    logic              avail;
    logic              fin;
    logic              fin_wrap;
    logic              fin_err;
    logic [LEN_W-1:0]  fin_len;

    always_comb begin
        d        = q;
        d.bwe    = 1'b0;
        d.cwe    = 1'b0;
        fin      = 1'b0;
        fin_wrap = 1'b0;
        fin_err  = 1'b0;
        fin_len  = '0;
        if (task_en) d.park = 1'b0;
        // a completion still in flight to this index counts as occupied
        busy  = q.cwe && (q.cidx == q.idx);
        avail = cur_empty && !busy && !d.park;

        unique case (q.st)
            WS_IDLE: begin
                if (rx_valid) begin
                    if (avail) begin
                        d.bwe   = 1'b1;
                        d.baddr = cur_ptr;
                        d.bdata = rx_data;
                        d.base  = cur_ptr;
                        d.cnt   = LEN_W'(1);
                        d.wrap  = cur_wrap;
                        d.trunc = 1'b0;
                        if (rx_last) begin
                            fin      = 1'b1;
                            fin_wrap = cur_wrap;
                            fin_err  = rx_error;
                            fin_len  = LEN_W'(1);
                        end else begin
                            d.st = WS_FILL;
                        end
                    end else begin
                        d.ovr  = 1'b1;
                        d.park = 1'b1;
                        if (!rx_last) d.st = WS_SKIP;
                    end
                end
            end
            WS_FILL: begin
                if (rx_valid) begin
                    if (q.cnt < LIMIT) begin
                        d.bwe   = 1'b1;
                        d.baddr = q.base + ADDR_W'(q.cnt);
                        d.bdata = rx_data;
                        d.cnt   = q.cnt + 1'b1;
                    end else begin
                        d.trunc = 1'b1;
                    end
                    if (rx_last) begin
                        fin      = 1'b1;
                        fin_wrap = q.wrap;
                        fin_err  = rx_error || d.trunc;
                        fin_len  = d.cnt;
                        d.st     = WS_IDLE;
                    end
                end
            end
            WS_SKIP: begin
                if (rx_valid && rx_last) d.st = WS_IDLE;
            end
            default: d.st = WS_IDLE;
        endcase

        if (fin) begin
            d.cwe  = 1'b1;
            d.cidx = q.idx;
            d.clen = fin_len;
            d.cst  = '0;
            d.cst[ST_WRAP] = fin_wrap;
            d.cst[ST_LAST] = 1'b1;
            d.cst[ST_ERR]  = fin_err;
            if (fin_wrap || q.idx == IDX_W'(NUM_DESC - 1)) d.idx = '0;
            else                                           d.idx = q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: WS_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cur_idx   = q.idx;
    assign mem_we    = q.bwe;
    assign mem_addr  = q.baddr;
    assign mem_wdata = q.bdata;
    assign cm_we     = q.cwe;
    assign cm_idx    = q.cidx;
    assign cm_st     = q.cst;
    assign cm_len    = q.clen;
    assign parked    = q.park;
    assign overrun   = q.ovr;
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
    import rxring_pkg::*;
#(
    parameter int NUM_DESC  = 4,
    parameter int MAX_FRAME = 1518,
    parameter int ADDR_W    = 13,
    parameter int LEN_W     = 16,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_error,
    input  logic              task_en,
    input  logic              sw_wr,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [3:0]        sw_status_in,
    input  logic [LEN_W-1:0]  sw_len_in,
    input  logic [ADDR_W-1:0] sw_ptr_in,
    output logic [3:0]        sw_status_out,
    output logic [LEN_W-1:0]  sw_len_out,
    output logic [ADDR_W-1:0] sw_ptr_out,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [IDX_W-1:0]  ring_pos,
    output logic              parked,
    output logic              overrun
);
    logic              eng_empty;
    logic              eng_wrap;
    logic [ADDR_W-1:0] eng_ptr;
    logic              cm_we;
    logic [IDX_W-1:0]  cm_idx;
    logic [ST_W-1:0]   cm_st;
    logic [LEN_W-1:0]  cm_len;

    rxring_desc_store #(
        .NUM_DESC(NUM_DESC), .MAX_FRAME(MAX_FRAME),
        .ADDR_W(ADDR_W), .LEN_W(LEN_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(sw_wr), .sw_idx(sw_idx),
        .sw_st_w(sw_status_in), .sw_len_w(sw_len_in), .sw_ptr_w(sw_ptr_in),
        .sw_st_r(sw_status_out), .sw_len_r(sw_len_out), .sw_ptr_r(sw_ptr_out),
        .eng_idx(ring_pos), .eng_empty(eng_empty), .eng_wrap(eng_wrap),
        .eng_ptr(eng_ptr),
        .cm_we(cm_we), .cm_idx(cm_idx), .cm_st(cm_st), .cm_len(cm_len)
    );

    rxring_walker #(
        .NUM_DESC(NUM_DESC), .MAX_FRAME(MAX_FRAME),
        .ADDR_W(ADDR_W), .LEN_W(LEN_W)
    ) u_walk (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_error(rx_error), .task_en(task_en),
        .cur_empty(eng_empty), .cur_wrap(eng_wrap), .cur_ptr(eng_ptr),
        .cur_idx(ring_pos),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cm_we(cm_we), .cm_idx(cm_idx), .cm_st(cm_st), .cm_len(cm_len),
        .parked(parked), .overrun(overrun)
    );
endmodule

// File: rtl/rxring_engine_chk.sv
module rxring_engine_chk #(
    parameter int MAX_FRAME = 1518,
    parameter int LEN_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             task_en,
    input logic             mem_we,
    input logic             cm_we,
    input logic [LEN_W-1:0] cm_len,
    input logic             parked,
    input logic             overrun
);
    // bytes written for the frame in progress
    logic [LEN_W:0] wr_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      wr_cnt_q <= '0;
        else if (cm_we)  wr_cnt_q <= '0;
        else if (mem_we) wr_cnt_q <= wr_cnt_q + 1'b1;
    end

    assert_write_follows_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(rx_valid));

    assert_len_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cm_we |-> (cm_len != '0));

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_parked_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && !task_en) |=> !mem_we);

    assert_frame_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wr_cnt_q < (LEN_W+1)'(MAX_FRAME)));
endmodule

bind rxring_engine rxring_engine_chk #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .task_en(task_en),
    .mem_we(mem_we), .cm_we(cm_we), .cm_len(cm_len),
    .parked(parked), .overrun(overrun)
);

// File: tb/rxring_engine_test.sv
`timescale 1ns/1ps
module rxring_engine_test;
    localparam int ND = 4;
    localparam int MF = 32;
    localparam int AW = 8;
    localparam int LW = 16;
    localparam int IW = 2;

    localparam logic [3:0] S_EMPTY = 4'd1;
    localparam logic [3:0] S_WRAP  = 4'd2;
    localparam logic [3:0] S_LAST  = 4'd4;
    localparam logic [3:0] S_ERR   = 4'd8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0, rx_last = 1'b0, rx_error = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          task_en = 1'b0, sw_wr = 1'b0;
    logic [IW-1:0] sw_idx = '0;
    logic [3:0]    sw_status_in = '0;
    logic [LW-1:0] sw_len_in = '0;
    logic [AW-1:0] sw_ptr_in = '0;
    logic [3:0]    sw_status_out;
    logic [LW-1:0] sw_len_out;
    logic [AW-1:0] sw_ptr_out;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [IW-1:0] ring_pos;
    logic          parked, overrun;

    int n_chk = 0;
    int n_bad = 0;
    int wcount = 0;
    int last_addr = -1;
    logic [7:0] mem [256];

    always #5 clk = ~clk;

    rxring_engine #(.NUM_DESC(ND), .MAX_FRAME(MF), .ADDR_W(AW), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_error(rx_error), .task_en(task_en),
        .sw_wr(sw_wr), .sw_idx(sw_idx), .sw_status_in(sw_status_in),
        .sw_len_in(sw_len_in), .sw_ptr_in(sw_ptr_in),
        .sw_status_out(sw_status_out), .sw_len_out(sw_len_out),
        .sw_ptr_out(sw_ptr_out), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .ring_pos(ring_pos), .parked(parked),
        .overrun(overrun)
    );

    // buffer memory model
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wcount    <= wcount + 1;
            last_addr <= int'(mem_addr);
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_frame(int n, bit err, logic [7:0] seed);
        for (int k = 0; k < n; k++) begin
            rx_valid = 1'b1;
            rx_data  = seed + 8'(k);
            rx_last  = (k == n - 1);
            rx_error = err && (k == n - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        rx_error = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_desc(int i, output int st, output int len, output int ptr);
        sw_idx = IW'(i);
        #1;
        st  = int'(sw_status_out);
        len = int'(sw_len_out);
        ptr = int'(sw_ptr_out);
    endtask

    task automatic write_desc(int i, logic [3:0] st, int len, int ptr);
        sw_idx       = IW'(i);
        sw_status_in = st;
        sw_len_in    = LW'(len);
        sw_ptr_in    = AW'(ptr);
        sw_wr        = 1'b1;
        @(negedge clk);
        sw_wr        = 1'b0;
    endtask

    task automatic check_bytes(string req, int base, int n, logic [7:0] seed);
        int bad = 0;
        for (int k = 0; k < n; k++)
            if (mem[base + k] !== seed + 8'(k)) bad++;
        chk(req, bad, 0);
    endtask

    task automatic t_reset();
        int st, len, ptr;
        for (int i = 0; i < ND; i++) begin
            read_desc(i, st, len, ptr);
            chk("R1 status", st, (i == ND - 1) ? int'(S_EMPTY | S_WRAP) : int'(S_EMPTY));
            chk("R1 length", len, 0);
            chk("R1 pointer", ptr, i * MF);
        end
        chk("R1 ring_pos", int'(ring_pos), 0);
        chk("R1 parked", int'(parked), 0);
        chk("R1 overrun", int'(overrun), 0);
    endtask

    task automatic t_basic();
        int st, len, ptr, w0;
        w0 = wcount;
        send_frame(20, 1'b0, 8'h40);
        read_desc(0, st, len, ptr);
        chk("R3 still empty one cycle after last byte", st & 1, 1);
        settle();
        chk("R2 write count", wcount - w0, 20);
        check_bytes("R2 byte order", 0, 20, 8'h40);
        read_desc(0, st, len, ptr);
        chk("R3 status", st, int'(S_LAST));
        chk("R3 length", len, 20);
        chk("R5 advance", int'(ring_pos), 1);
    endtask

    task automatic t_error();
        int st, len, ptr;
        send_frame(18, 1'b1, 8'h60);
        settle();
        read_desc(1, st, len, ptr);
        chk("R4 status", st, int'(S_LAST | S_ERR));
        chk("R4 length", len, 18);
        chk("R4 consumed", int'(ring_pos), 2);
        check_bytes("R4 data", 32, 18, 8'h60);
    endtask

    task automatic t_wrap();
        int st, len, ptr;
        send_frame(5, 1'b0, 8'h70);
        settle();
        send_frame(6, 1'b0, 8'h80);
        settle();
        read_desc(3, st, len, ptr);
        chk("R5 wrap kept", st, int'(S_LAST | S_WRAP));
        chk("R5 length", len, 6);
        chk("R5 wrap to zero", int'(ring_pos), 0);
    endtask

    task automatic t_overrun();
        int st, len, ptr, w0;
        w0 = wcount;
        send_frame(10, 1'b0, 8'hC0);
        settle();
        chk("R6 no writes", wcount - w0, 0);
        chk("R6 overrun", int'(overrun), 1);
        chk("R6 parked", int'(parked), 1);
        chk("R6 ring_pos", int'(ring_pos), 0);
        read_desc(0, st, len, ptr);
        chk("R6 descriptor untouched", len, 20);
    endtask

    task automatic t_parked();
        int st, len, ptr, w0;
        write_desc(0, S_EMPTY, 0, 0);
        read_desc(0, st, len, ptr);
        chk("R9 status readback", st, int'(S_EMPTY));
        chk("R9 length readback", len, 0);
        chk("R9 pointer readback", ptr, 0);
        w0 = wcount;
        send_frame(6, 1'b0, 8'hD0);
        settle();
        chk("R7 dropped while parked", wcount - w0, 0);
        task_en = 1'b1;
        @(negedge clk);
        task_en = 1'b0;
        chk("R7 unparked", int'(parked), 0);
        send_frame(8, 1'b0, 8'h90);
        settle();
        read_desc(0, st, len, ptr);
        chk("R7 stored status", st, int'(S_LAST));
        chk("R7 stored length", len, 8);
        check_bytes("R7 data", 0, 8, 8'h90);
        chk("R6 overrun sticky", int'(overrun), 1);
    endtask

    task automatic t_trunc();
        int st, len, ptr, w0;
        write_desc(1, S_EMPTY, 0, 32);
        w0 = wcount;
        send_frame(40, 1'b0, 8'h10);
        settle();
        chk("R8 writes limited", wcount - w0, MF);
        chk("R8 last address", last_addr, 32 + MF - 1);
        check_bytes("R8 data", 32, MF, 8'h10);
        read_desc(1, st, len, ptr);
        chk("R8 status", st, int'(S_LAST | S_ERR));
        chk("R8 length", len, MF);
        chk("R8 ring_pos", int'(ring_pos), 2);
    endtask

    task automatic t_short_ring();
        int st, len, ptr, w0;
        write_desc(2, S_EMPTY | S_WRAP, 0, 64);
        send_frame(1, 1'b0, 8'hA5);
        settle();
        read_desc(2, st, len, ptr);
        chk("R3 one-byte status", st, int'(S_LAST | S_WRAP));
        chk("R3 one-byte length", len, 1);
        chk("R3 one-byte data", int'(mem[64]), 8'hA5);
        chk("R5 short ring wrap", int'(ring_pos), 0);
        w0 = wcount;
        repeat (20) @(negedge clk);
        chk("R2 idle no writes", wcount - w0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_error();
        t_wrap();
        t_overrun();
        t_parked();
        t_trunc();
        t_short_ring();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule